// File: doc/BRIEF.md
# Dual-Edge Sampled XOR Phase Detector

This block compares an oscillator square wave with a reference square wave, such as the sign of a resonant tank current, and reports their phase relation as a small digital value that a digital loop filter can use. The two signals pass through one XOR. The result is captured twice per reference period: once on the reference rising edge and once on the falling edge. A single-edge detector updates once per period. This one updates every half-cycle, so a loop can follow a phase step that occurs between one half-cycle and the next.

Both inputs are asynchronous to the system clock. Each one passes through a synchronizer of the same depth, so the two stay aligned. The reference edges are found on the system clock. In the default gated form, only the register that captured most recently drives the output. The older capture, which describes the previous half-cycle, is never mixed in. A parameter selects a plain averaged form instead, which adds both captures. The detector reports a neutral midpoint until both registers hold a real capture.

Top module: `phdet_dual_edge`

## Requirements
- R1: A synchronous active-high `rst` sets `pd_sum` to 1 and `pd_drive` to 0.
- R2: A reference edge applied before clock edge 1 changes the outputs after clock edge SYNC_STAGES+2 (edge 4 by default). The outputs still hold their old values after edge SYNC_STAGES+1.
- R3: A capture value of 1 means mismatch. On a reference rising edge, the rise register captures 1 when the synchronized oscillator is low. On a falling edge, the fall register captures 1 when the oscillator is high.
- R4: `pd_sum` stays at 1 and `pd_drive` at 0 until both the rise register and the fall register have captured at least once since reset. This includes the case where only rising edges have been seen.
- R5: With GATE_HALVES=1, once primed, `pd_sum` is 2 when the most recently written register holds 1 and 0 when it holds 0. It never takes the value 1 or 3.
- R6: Once primed, `pd_drive` equals the value held in the most recently written register.
- R7: Oscillator changes between reference edges have no effect on the outputs.
- R8: With GATE_HALVES=0, once primed, `pd_sum` is the sum of the two registers: 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | Oscillator square wave, asynchronous |
| ref_in | input | 1 | Reference phase square wave, asynchronous |
| pd_sum | output | 2 | Phase value 0, 1 or 2; 1 is neutral |
| pd_drive | output | 1 | One-bit phase drive from the active capture |

## Verification
Suppose a capture register holds a wrong value, or the half-cycle selector points at the stale register. In either case `pd_sum` shows the wrong level within SYNC_STAGES+2 clocks of the reference edge that should have set it, and the error lasts until the next edge of the opposite polarity. A wrong primed flag shows at the ports as an early departure from the neutral value 1, or as a detector that never leaves it. Either one is visible on the first half-cycle after both edge polarities have occurred.

// File: rtl/phdet_pkg.sv
package phdet_pkg;
  localparam int SUM_W = 2;
  typedef logic [SUM_W-1:0] psum_t;
  localparam psum_t PSUM_NEUTRAL = psum_t'(1);
endpackage

// File: rtl/phdet_sync.sv
module phdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/phdet_edges.sv
module phdet_edges (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;

  // R2: one strobe per edge, never two in a row
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
  assert_fall_single_R2: assert property (@(posedge clk) disable iff (rst) fall |=> !fall);
endmodule

// File: rtl/phdet_sampler.sv
module phdet_sampler (
  input  logic clk,
  input  logic rst,
  input  logic osc_s,
  input  logic ref_s,
  input  logic rise,
  input  logic fall,
  output logic samp_hi,
  output logic samp_lo,
  output logic hi_active,
  output logic primed
);
  logic xor_now;
  logic seen_hi, seen_lo;

  // one shared XOR serves both half-cycles
  assign xor_now = osc_s ^ ref_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_hi   <= 1'b0;
      samp_lo   <= 1'b0;
      seen_hi   <= 1'b0;
      seen_lo   <= 1'b0;
      hi_active <= 1'b0;
    end else begin
      if (rise) begin
        samp_hi   <= xor_now;
        seen_hi   <= 1'b1;
        hi_active <= 1'b1;
      end
      if (fall) begin
        samp_lo   <= xor_now;
        seen_lo   <= 1'b1;
        hi_active <= 1'b0;
      end
    end
  end

  assign primed = seen_hi & seen_lo;

  assert_rise_capture_R3: assert property (@(posedge clk) disable iff (rst)
    rise |=> (samp_hi == !$past(osc_s)));
  assert_fall_capture_R3: assert property (@(posedge clk) disable iff (rst)
    fall |=> (samp_lo == $past(osc_s)));
  assert_hi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(samp_hi));
  assert_lo_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(samp_lo));
  assert_select_R6: assert property (@(posedge clk) disable iff (rst)
    rise |=> hi_active);
endmodule

// File: rtl/phdet_combine.sv
module phdet_combine
  import phdet_pkg::*;
#(
  parameter bit GATE_HALVES = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  samp_hi,
  input  logic  samp_lo,
  input  logic  hi_active,
  input  logic  primed,
  output psum_t pd_sum,
  output logic  pd_drive
);
  logic  active;
  psum_t next_sum;

  assign active = hi_active ? samp_hi : samp_lo;

  generate
    if (GATE_HALVES) begin : g_gated
      assign next_sum = {active, 1'b0};
    end else begin : g_avg
      assign next_sum = {1'b0, samp_hi} + {1'b0, samp_lo};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !primed) begin
      pd_sum   <= PSUM_NEUTRAL;
      pd_drive <= 1'b0;
    end else begin
      pd_sum   <= next_sum;
      pd_drive <= active;
    end
  end

  assert_sum_range_R5: assert property (@(posedge clk) disable iff (rst) pd_sum != 2'd3);
  assert_neutral_R4: assert property (@(posedge clk) disable iff (rst)
    !primed |=> (pd_sum == PSUM_NEUTRAL && !pd_drive));

  generate
    if (GATE_HALVES) begin : g_chk
      assert_gated_level_R5: assert property (@(posedge clk) disable iff (rst)
        primed |=> (pd_sum != 2'd1));
      assert_drive_match_R6: assert property (@(posedge clk) disable iff (rst)
        primed |=> (pd_drive == pd_sum[1]));
    end
  endgenerate
endmodule

// File: rtl/phdet_dual_edge.sv
module phdet_dual_edge #(
  parameter int SYNC_STAGES = 2,
  parameter bit GATE_HALVES = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_in,
  input  logic       ref_in,
  output logic [1:0] pd_sum,
  output logic       pd_drive
);
  logic osc_s, ref_s, rise, fall;
  logic samp_hi, samp_lo, hi_active, primed;

  phdet_sync #(.STAGES(SYNC_STAGES)) u_sync_osc (
    .clk(clk), .rst(rst), .d_in(osc_in), .q(osc_s));
  phdet_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
    .clk(clk), .rst(rst), .d_in(ref_in), .q(ref_s));

  phdet_edges u_edges (
    .clk(clk), .rst(rst), .level(ref_s), .rise(rise), .fall(fall));

  phdet_sampler u_samp (
    .clk(clk), .rst(rst), .osc_s(osc_s), .ref_s(ref_s), .rise(rise), .fall(fall),
    .samp_hi(samp_hi), .samp_lo(samp_lo), .hi_active(hi_active), .primed(primed));

  phdet_combine #(.GATE_HALVES(GATE_HALVES)) u_comb (
    .clk(clk), .rst(rst), .samp_hi(samp_hi), .samp_lo(samp_lo),
    .hi_active(hi_active), .primed(primed), .pd_sum(pd_sum), .pd_drive(pd_drive));

  assert_reset_R1: assert property (@(posedge clk) rst |=> (pd_sum == 2'd1 && !pd_drive));
endmodule

// File: tb/sim_phdet_dual_edge.sv
module sim_phdet_dual_edge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_in = 1'b0;
  logic ref_in = 1'b0;
  logic [1:0] sum_g, sum_a;
  logic drv_g, drv_a;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phdet_dual_edge #(.SYNC_STAGES(2), .GATE_HALVES(1'b1)) u0 (
    .clk(clk), .rst(rst), .osc_in(osc_in), .ref_in(ref_in), .pd_sum(sum_g), .pd_drive(drv_g));
  phdet_dual_edge #(.SYNC_STAGES(2), .GATE_HALVES(1'b0)) u1 (
    .clk(clk), .rst(rst), .osc_in(osc_in), .ref_in(ref_in), .pd_sum(sum_a), .pd_drive(drv_a));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_with(input logic new_ref, input logic osc_at);
    osc_in = osc_at;
    settle(4);
    ref_in = new_ref;
    settle(6);
  endtask

  task automatic t_reset;
    settle(1);
    chk("R1 sum", sum_g, 2'd1);
    chk("R1 drive", {1'b0, drv_g}, 2'd0);
    chk("R1 avg sum", sum_a, 2'd1);
    rst = 1'b0;
    settle(3);
  endtask

  task automatic t_neutral;
    edge_with(1'b1, 1'b0);
    chk("R4 rise only", sum_g, 2'd1);
    chk("R4 rise only avg", sum_a, 2'd1);
    edge_with(1'b0, 1'b0);
    chk("R5 matched fall", sum_g, 2'd0);
    chk("R6 drive", {1'b0, drv_g}, 2'd0);
    chk("R8 avg", sum_a, 2'd1);
  endtask

  task automatic t_latency;
    osc_in = 1'b0;
    settle(4);
    ref_in = 1'b1;
    settle(3);
    chk("R2 old after edge 3", sum_g, 2'd0);
    settle(1);
    chk("R2 new after edge 4", sum_g, 2'd2);
    chk("R6 drive", {1'b0, drv_g}, 2'd1);
    chk("R8 avg", sum_a, 2'd1);
  endtask

  task automatic t_ignore;
    for (int i = 0; i < 3; i++) begin
      osc_in = ~osc_in;
      settle(3);
    end
    settle(4);
    chk("R7 osc ignored", sum_g, 2'd2);
    chk("R7 osc ignored avg", sum_a, 2'd1);
  endtask

  task automatic t_halves;
    edge_with(1'b0, 1'b1);
    chk("R3 fall osc high", sum_g, 2'd2);
    chk("R8 avg", sum_a, 2'd2);
    edge_with(1'b1, 1'b1);
    chk("R3 rise osc high", sum_g, 2'd0);
    chk("R6 drive", {1'b0, drv_g}, 2'd0);
    chk("R8 avg", sum_a, 2'd1);
    edge_with(1'b0, 1'b0);
    chk("R5 fall match", sum_g, 2'd0);
    chk("R8 avg", sum_a, 2'd0);
    edge_with(1'b1, 1'b0);
    chk("R5 rise mismatch", sum_g, 2'd2);
    chk("R8 avg", sum_a, 2'd1);
  endtask

  task automatic t_reset_mid;
    rst = 1'b1;
    settle(2);
    chk("R1 mid sum", sum_g, 2'd1);
    chk("R1 mid drive", {1'b0, drv_g}, 2'd0);
    rst = 1'b0;
    settle(8);
    chk("R4 rise after reset", sum_g, 2'd1);
    chk("R4 rise after reset avg", sum_a, 2'd1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    settle(3);
    t_reset;
    t_neutral;
    t_latency;
    t_ignore;
    t_halves;
    t_reset_mid;
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run;
    end
  end
endmodule